// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns a single PWM command into two registered gate enables for the high and low switches of a half-bridge. It never lets both switches conduct at the same time. Dead time is not a fixed delay. The block waits for sensed feedback before turning a switch on: the switch node must fall below threshold before the low side turns on, and the low-side gate must fall below threshold before the high side turns on. Analog comparators appear here only as digital flags.

A run input (low means shut down) and a supply-good flag force both gates off. A brake request forces the low side on and the high side off. When any of these overrides is released, the controller first passes through a both-off state. It then runs the normal handshake for the current PWM level. If the switch node does not fall within a timeout, counted in clock cycles and 400 ns by default, the low side is forced on. It stays on until PWM rises again.

The states are:
- SAFE: both gates off.
- BRAKE: low side on.
- HS_WAIT: both off, waiting for the low-gate flag.
- HS_ON: high side on.
- LS_WAIT: both off, waiting for the switch-node flag or the timeout.
- LS_ON: low side on.
- LS_FORCED: low side on after the timeout.

The transitions are:
- Overrides: shutdown or low supply goes to SAFE from any state. Otherwise a brake request goes to BRAKE from any state.
- Leaving an override: BRAKE goes to SAFE when the brake request is released. SAFE goes to HS_WAIT or LS_WAIT according to the PWM level.
- Normal operation: HS_WAIT goes to HS_ON on the low-gate flag. LS_WAIT goes to LS_ON on the switch-node flag, or to LS_FORCED on timeout. HS_ON goes to LS_WAIT when PWM is low. LS_ON and LS_FORCED go to HS_WAIT when PWM is high.
- Abort: HS_WAIT goes to LS_WAIT when PWM goes low. LS_WAIT goes to HS_WAIT when PWM goes high.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1 in any cycle.
- R2: When `run_en` is 0 on a clock edge, both gate outputs are 0 after that edge, whatever the PWM and brake inputs are.
- R3: When `supply_ok` is 0 on a clock edge, both gate outputs are 0 after that edge, whatever the PWM and brake inputs are.
- R4: When `run_en`=1, `supply_ok`=1 and `brake_req`=1 on an edge, then after that edge `hs_gate`=0 and `ls_gate`=1, whatever the PWM level.
- R5: PWM rising (noninverting), from the low side on:
  - The first edge that samples `pwm_in`=1 drives `ls_gate` to 0 and keeps `hs_gate` at 0.
  - `hs_gate` then rises on the first later edge that samples `lg_low`=1.
  - While `lg_low` stays 0, both gates stay 0.
- R6: PWM falling, from the high side on:
  - The first edge that samples `pwm_in`=0 drives `hs_gate` to 0 and keeps `ls_gate` at 0.
  - `ls_gate` then rises on the first later edge that samples `sw_low`=1.
- R7: Suppose `sw_low` stays 0 after `hs_gate` fell on edge e. Then `ls_gate` rises on edge e+TIMEOUT_CYC, where TIMEOUT_CYC = ceil(TIMEOUT_NS*1000/CLK_PERIOD_PS) with a minimum of 2.
- R8: Once the low side has been forced on by the timeout, it stays on while `pwm_in` stays 0, whatever `sw_low` and `lg_low` do. The first edge that samples `pwm_in`=1 drives `ls_gate` to 0.
- R9: Leaving shutdown, low supply or brake:
  - The first edge after the release drives both gates to 0.
  - The high side is reached only through the `lg_low` handshake: three edges after a brake release, or two edges after a shutdown or supply release, with `lg_low`=1.
- R10: A PWM change while a handshake is waiting aborts the pending turn-on and starts the sequence for the new level. The timeout count restarts from the edge that sampled the change.
- R11: During reset, and on the first edges after it, both outputs are 0 until the handshake for the current PWM level has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | PWM command: 1 selects the high side, 0 the low side |
| run_en | input | 1 | 0 shuts the driver down (both gates off) |
| supply_ok | input | 1 | 0 means undervoltage (both gates off) |
| brake_req | input | 1 | 1 forces the low side on and the high side off |
| sw_low | input | 1 | Switch-node voltage below threshold |
| lg_low | input | 1 | Low-side gate voltage below threshold |
| hs_gate | output | 1 | High-side gate enable, registered |
| ls_gate | output | 1 | Low-side gate enable, registered |

## Verification
The checker watches four things on every cycle:
- that both gates are never on together;
- the one-edge response to shutdown, low supply and brake;
- that every high-side rise follows a sampled low-gate flag with PWM high and the low side off;
- that every low-side rise not caused by the brake follows a cycle with the high side off and PWM low.

Only the bench scenarios can show the timing-dependent behaviour: the exact cycle on which the timeout forces the low side on, that the forced state is held until the next PWM rise, the restart of the count after an aborted handshake, and the number of edges needed to reach the high side after each kind of override release.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;

    typedef enum logic [2:0] {
        ST_SAFE      = 3'd0,
        ST_BRAKE     = 3'd1,
        ST_HS_WAIT   = 3'd2,
        ST_HS_ON     = 3'd3,
        ST_LS_WAIT   = 3'd4,
        ST_LS_ON     = 3'd5,
        ST_LS_FORCED = 3'd6
    } hb_state_t;

    function automatic logic hs_drive(input hb_state_t st);
        return (st == ST_HS_ON);
    endfunction

    function automatic logic ls_drive(input hb_state_t st);
        return (st == ST_LS_ON) || (st == ST_LS_FORCED) || (st == ST_BRAKE);
    endfunction

endpackage

// File: rtl/hbd_edge_det.sv
`timescale 1ns/1ps
module hbd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic toggled
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_in;
        end
    end

    // Any change of level since the previous edge
    assign toggled = level_in ^ level_q;

endmodule

// File: rtl/hbd_timeout.sv
`timescale 1ns/1ps
module hbd_timeout #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);

    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Asserted during the LIMIT-th cycle of an uninterrupted run
    assign expired = run && !clear && (cnt_q == LAST);

endmodule

// File: rtl/hbd_fsm.sv
`timescale 1ns/1ps
module hbd_fsm
    import hbd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_in,
    input  logic      run_en,
    input  logic      supply_ok,
    input  logic      brake_req,
    input  logic      sw_low,
    input  logic      lg_low,
    input  logic      tmo_expired,
    output hb_state_t state,
    output logic      hs_gate,
    output logic      ls_gate
);

    hb_state_t state_nx;

    // Next-state logic: overrides first, then the handshake
    always_comb begin
        state_nx = state;
        if (!run_en || !supply_ok) begin
            state_nx = ST_SAFE;
        end else if (brake_req) begin
            state_nx = ST_BRAKE;
        end else begin
            unique case (state)
                ST_SAFE:      state_nx = pwm_in ? ST_HS_WAIT : ST_LS_WAIT;
                ST_BRAKE:     state_nx = ST_SAFE;
                ST_HS_WAIT: begin
                    if (!pwm_in)     state_nx = ST_LS_WAIT;
                    else if (lg_low) state_nx = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (!pwm_in)     state_nx = ST_LS_WAIT;
                end
                ST_LS_WAIT: begin
                    if (pwm_in)           state_nx = ST_HS_WAIT;
                    else if (sw_low)      state_nx = ST_LS_ON;
                    else if (tmo_expired) state_nx = ST_LS_FORCED;
                end
                ST_LS_ON: begin
                    if (pwm_in)      state_nx = ST_HS_WAIT;
                end
                ST_LS_FORCED: begin
                    if (pwm_in)      state_nx = ST_HS_WAIT;
                end
                default:             state_nx = ST_SAFE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SAFE;
        end else begin
            state <= state_nx;
        end
    end

    // Output register, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_gate <= 1'b0;
            ls_gate <= 1'b0;
        end else begin
            hs_gate <= hs_drive(state_nx);
            ls_gate <= ls_drive(state_nx);
        end
    end

endmodule

// File: rtl/hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl
    import hbd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int TIMEOUT_NS    = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic run_en,
    input  logic supply_ok,
    input  logic brake_req,
    input  logic sw_low,
    input  logic lg_low,
    output logic hs_gate,
    output logic ls_gate
);

    localparam int TMO_RAW     = (TIMEOUT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int TIMEOUT_CYC = (TMO_RAW < 2) ? 2 : TMO_RAW;

    hb_state_t state;
    logic      pwm_toggled;
    logic      tmo_expired;

    hbd_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pwm_in),
        .toggled  (pwm_toggled)
    );

    hbd_timeout #(
        .LIMIT (TIMEOUT_CYC)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_LS_WAIT),
        .clear   (pwm_toggled),
        .expired (tmo_expired)
    );

    hbd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .run_en      (run_en),
        .supply_ok   (supply_ok),
        .brake_req   (brake_req),
        .sw_low      (sw_low),
        .lg_low      (lg_low),
        .tmo_expired (tmo_expired),
        .state       (state),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate)
    );

endmodule

// File: rtl/hbd_checker.sv
`timescale 1ns/1ps
module hbd_checker (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic run_en,
    input logic supply_ok,
    input logic brake_req,
    input logic sw_low,
    input logic lg_low,
    input logic hs_gate,
    input logic ls_gate
);

    a_r1_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    a_r2_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_gate && !ls_gate));

    a_r3_undervolt_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_gate && !ls_gate));

    a_r4_brake_low_side: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && supply_ok && brake_req) |=> (!hs_gate && ls_gate));

    // R5 and R9: the high side rises only after a sampled low-gate flag
    a_r5_hs_after_lg_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(lg_low) && $past(pwm_in) && !$past(ls_gate)));

    // R6 and R7: a low-side rise not caused by the brake follows high side off
    a_r6_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_gate) && !$past(brake_req)) |-> (!$past(hs_gate) && !$past(pwm_in)));

    a_r6_pwm_low_drops_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !hs_gate);

endmodule

bind hb_deadtime_ctrl hbd_checker i_chk (.*);

// File: tb/test_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module test_hb_deadtime_ctrl;

    localparam int CLK_PS = 8000;
    localparam int TMO_NS = 40;
    localparam int TO     = (TMO_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n, pwm_in, run_en, supply_ok, brake_req, sw_low, lg_low;
    logic hs_gate, ls_gate;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    hb_deadtime_ctrl #(.CLK_PERIOD_PS(CLK_PS), .TIMEOUT_NS(TMO_NS)) i_hb_deadtime_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .run_en(run_en),
        .supply_ok(supply_ok), .brake_req(brake_req), .sw_low(sw_low),
        .lg_low(lg_low), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ehs, input logic els, input string tag);
        n_run++;
        if (hs_gate !== ehs || ls_gate !== els) begin
            n_fail++;
            $display("FAIL %s: hs,ls=%b%b expected %b%b at %0t", tag, hs_gate, ls_gate, ehs, els, $time);
        end
        n_run++;
        if (hs_gate && ls_gate) begin
            n_fail++;
            $display("FAIL R1: hs,ls=11 expected not both 1 at %0t", $time);
        end
    endtask

    task automatic set_ctl(input logic [3:0] v);
        run_en    = v[3];
        supply_ok = v[2];
        brake_req = v[1];
        pwm_in    = v[0];
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pwm_in = 1'b0; run_en = 1'b0; supply_ok = 1'b0; brake_req = 1'b0;
        sw_low = 1'b0; lg_low = 1'b0;
        cyc(3);
        chk(1'b0, 1'b0, "R11 in reset");

        // Leave reset with PWM low: both off first, then the low side
        rst_n = 1'b1; run_en = 1'b1; supply_ok = 1'b1; sw_low = 1'b1;
        cyc(1);
        chk(1'b0, 1'b0, "R11 first edge");
        cyc(1);
        chk(1'b0, 1'b1, "R11 low side");

        // Exhaustive sweep over (previous, current) override/PWM settings
        lg_low = 1'b1; sw_low = 1'b1;
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [3:0] pv, cv;
                logic ehs, els;
                logic p_norm, c_en;
                string tag;
                pv = 4'(p); cv = 4'(c);
                set_ctl(pv);
                cyc(4);
                set_ctl(cv);
                cyc(1);
                p_norm = pv[3] & pv[2] & ~pv[1];
                c_en   = cv[3] & cv[2];
                tag = !cv[3] ? "R2" : (!cv[2] ? "R3" : (cv[1] ? "R4" : "R9"));
                if (!c_en)                              begin ehs = 1'b0; els = 1'b0; end
                else if (cv[1])                         begin ehs = 1'b0; els = 1'b1; end
                else if (p_norm && (pv[0] == cv[0]))    begin ehs = cv[0]; els = ~cv[0]; end
                else                                    begin ehs = 1'b0; els = 1'b0; end
                chk(ehs, els, tag);
                cyc(3);
                if (!c_en)       begin ehs = 1'b0; els = 1'b0; end
                else if (cv[1])  begin ehs = 1'b0; els = 1'b1; end
                else             begin ehs = cv[0]; els = ~cv[0]; end
                chk(ehs, els, tag);
            end
        end

        // R9: brake release with PWM high needs three edges to reach the high side
        set_ctl(4'b1111); cyc(3);
        set_ctl(4'b1101);
        cyc(1); chk(1'b0, 1'b0, "R9 brake release edge 1");
        cyc(1); chk(1'b0, 1'b0, "R9 brake release edge 2");
        cyc(1); chk(1'b1, 1'b0, "R9 brake release edge 3");

        // R5: rising PWM waits on the low-gate flag
        set_ctl(4'b1100); cyc(4);
        lg_low = 1'b0; pwm_in = 1'b1;
        cyc(1); chk(1'b0, 1'b0, "R5 ls dropped");
        cyc(3); chk(1'b0, 1'b0, "R5 still waiting");
        lg_low = 1'b1;
        cyc(1); chk(1'b1, 1'b0, "R5 hs on");

        // R6: falling PWM waits on the switch-node flag
        sw_low = 1'b0; pwm_in = 1'b0;
        cyc(1); chk(1'b0, 1'b0, "R6 hs dropped");
        sw_low = 1'b1;
        cyc(1); chk(1'b0, 1'b1, "R6 ls on");

        // R10: abort a high-side wait, then the count restarts from the abort edge
        lg_low = 1'b0; pwm_in = 1'b1; sw_low = 1'b0;
        cyc(2); chk(1'b0, 1'b0, "R10 waiting for hs");
        pwm_in = 1'b0;
        cyc(TO); chk(1'b0, 1'b0, "R10 before restarted timeout");
        cyc(1);  chk(1'b0, 1'b1, "R10 restarted timeout");

        // R7: sweep the cycle on which the switch-node flag arrives
        for (int d = 1; d <= TO + 2; d++) begin
            sw_low = 1'b1; lg_low = 1'b1; pwm_in = 1'b1;
            cyc(4);
            chk(1'b1, 1'b0, "R7 setup hs on");
            sw_low = 1'b0; pwm_in = 1'b0;
            for (int k = 1; k <= TO + 3; k++) begin
                int rise;
                cyc(1);
                rise = ((d < TO) ? d : TO) + 1;
                chk(1'b0, (k >= rise) ? 1'b1 : 1'b0, "R7 timeout sweep");
                sw_low = (k >= d) ? 1'b1 : 1'b0;
            end
        end

        // R8: forced state held, then released by PWM rise
        sw_low = 1'b1; lg_low = 1'b1; pwm_in = 1'b1;
        cyc(4);
        sw_low = 1'b0; pwm_in = 1'b0;
        cyc(TO + 1); chk(1'b0, 1'b1, "R8 forced on");
        for (int k = 0; k < 6; k++) begin
            sw_low = k[0]; lg_low = k[1];
            cyc(1); chk(1'b0, 1'b1, "R8 forced held");
        end
        lg_low = 1'b0; pwm_in = 1'b1;
        cyc(1); chk(1'b0, 1'b0, "R8 released by pwm rise");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule